// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block does lane-wise arithmetic on one 32-bit word. An operation code selects how the word is split. It can be two signed Q15 halfwords or four unsigned bytes. Add and subtract each come in a wrapping form and a clamping form. There is also a saturating absolute value, either per halfword or on the whole word. A last operation adds the four bytes of the first operand into one zero-extended result.

The block sits in an execution pipeline. A caller presents two operands and an operation code with a valid strobe, and the result register loads on that clock edge. The result holds between strobes. Any lane that clamps raises a sticky overflow flag, which stays set until the caller pulses the clear input.

Top module: `simd_sat_adder`

## Requirements
- R1: After reset, `result` is 0 and `ovf_flag` is 0.
- R2: `result` loads at the rising edge on which `in_valid` is 1, so it is visible one cycle later. While `in_valid` is 0, `result` keeps its value.
- R3: Op 0 adds and op 2 subtracts (A minus B) each 16-bit lane modulo 2^16. Lane 0 is bits 15:0. No carry or borrow crosses lanes, and these ops never set `ovf_flag`.
- R4: Op 1 (add) and op 3 (subtract) treat each 16-bit lane as signed. A positive overflow clamps the lane to 0x7FFF, a negative overflow clamps it to 0x8000, and a clamping lane sets `ovf_flag`.
- R5: Op 4 adds and op 6 subtracts each 8-bit lane modulo 256. Lane 0 is bits 7:0. There is no cross-lane carry and no flag.
- R6: Op 5 adds each unsigned byte lane and clamps to 0xFF on carry. Op 7 subtracts and clamps to 0x00 on borrow. A clamping lane sets `ovf_flag`.
- R7: Op 8 replaces each signed 16-bit lane of A by its absolute value. A lane equal to 0x8000 becomes 0x7FFF and sets `ovf_flag`.
- R8: Op 9 takes the absolute value of A as one signed 32-bit value. 0x80000000 becomes 0x7FFFFFFF and sets `ovf_flag`.
- R9: Op 10 returns the sum of the four zero-extended bytes of A. B is ignored, the bits above the sum width are 0, and the flag is not set.
- R10: `ovf_flag` stays set until a cycle with `ovf_clr` 1. If that same cycle also clamps a lane, the flag stays set.
- R11: Op codes 11 to 15 load 0 into `result` and leave `ovf_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| result | output | 32 | Registered result |
| ovf_flag | output | 1 | Sticky lane overflow flag |

## Verification
The bench builds the block with a 32-bit word, 16-bit halfwords, 8-bit bytes and the tree form of the byte reduction. That tree has two levels over four leaves, so a misrouted node shows up in the byte sums. These widths leave room for lane-boundary vectors where a low lane wraps right next to a high lane, and for both clamp directions in each lane family. They also reach the single most-negative operand of each absolute-value form.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_HADD     = 4'd0,
      OP_HADD_SAT = 4'd1,
      OP_HSUB     = 4'd2,
      OP_HSUB_SAT = 4'd3,
      OP_BADD     = 4'd4,
      OP_BADD_SAT = 4'd5,
      OP_BSUB     = 4'd6,
      OP_BSUB_SAT = 4'd7,
      OP_HABS_SAT = 4'd8,
      OP_WABS_SAT = 4'd9,
      OP_BSUM     = 4'd10
   } simd_op_e;

   typedef struct packed {
      logic half_arith;
      logic byte_arith;
      logic half_abs;
      logic word_abs;
      logic byte_sum;
      logic sub;
      logic sat;
   } simd_ctl_t;

   // Op code to datapath steering; codes 0..7 carry sub in bit 1 and sat in bit 0
   function automatic simd_ctl_t decode_op(input logic [OP_W-1:0] code);
      simd_ctl_t c;
      c     = '0;
      c.sub = code[1];
      c.sat = code[0];
      case (code)
         OP_HADD, OP_HADD_SAT, OP_HSUB, OP_HSUB_SAT: c.half_arith = 1'b1;
         OP_BADD, OP_BADD_SAT, OP_BSUB, OP_BSUB_SAT: c.byte_arith = 1'b1;
         OP_HABS_SAT:                                c.half_abs   = 1'b1;
         OP_WABS_SAT:                                c.word_abs   = 1'b1;
         OP_BSUM:                                    c.byte_sum   = 1'b1;
         default:                                    c            = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/simd_sat_lane.sv
// One add/subtract lane, signed or unsigned, with optional clamping.
module simd_sat_lane #(
   parameter int W           = 16,
   parameter bit SIGNED_LANE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         sat_i,
   output logic [W-1:0] y_o,
   output logic         clip_o
);

   logic [W:0]   ext_a;
   logic [W:0]   ext_b;
   logic [W:0]   raw;
   logic         over;
   logic [W-1:0] clamp;

   generate
      if (W < 2) begin : g_bad_width
         $error("simd_sat_lane: W must be at least 2");
      end
      if (SIGNED_LANE) begin : g_signed
         assign ext_a = {a_i[W-1], a_i};
         assign ext_b = {b_i[W-1], b_i};
         assign raw   = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
         // sign of the extended sum disagrees with the lane sign bit
         assign over  = raw[W] ^ raw[W-1];
         assign clamp = raw[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end else begin : g_unsigned
         assign ext_a = {1'b0, a_i};
         assign ext_b = {1'b0, b_i};
         assign raw   = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
         // carry out on add, borrow on subtract
         assign over  = raw[W];
         assign clamp = sub_i ? {W{1'b0}} : {W{1'b1}};
      end
   endgenerate

   assign clip_o = sat_i & over;
   assign y_o    = clip_o ? clamp : raw[W-1:0];

endmodule

// File: rtl/simd_abs_lane.sv
// Saturating absolute value of one signed lane.
module simd_abs_lane #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   output logic [W-1:0] y_o,
   output logic         clip_o
);

   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] negated;

   assign negated = (~a_i) + {{(W-1){1'b0}}, 1'b1};
   assign clip_o  = (a_i == MOST_NEG);
   assign y_o     = clip_o   ? MOST_POS :
                    a_i[W-1] ? negated  : a_i;

endmodule

// File: rtl/simd_byte_sum.sv
// Sum of zero-extended byte lanes; chain or balanced tree.
module simd_byte_sum #(
   parameter int NB       = 4,
   parameter int BYTE_W   = 8,
   parameter int OUT_W    = 32,
   parameter bit USE_TREE = 1'b1
) (
   input  logic [NB*BYTE_W-1:0] bytes_i,
   output logic [OUT_W-1:0]     sum_o
);

   localparam int SUM_W = BYTE_W + $clog2(NB);

   logic [SUM_W-1:0] total;

   generate
      if (SUM_W > OUT_W) begin : g_bad_out
         $error("simd_byte_sum: sum does not fit the output");
      end
      if (USE_TREE) begin : g_tree
         if ((NB & (NB - 1)) != 0 || NB < 2) begin : g_bad_nb
            $error("simd_byte_sum: tree form needs a power-of-two lane count");
         end
         // heap layout: leaves at NB..2NB-1, root at 1
         logic [SUM_W-1:0] node [1:2*NB-1];
         for (genvar j = 0; j < NB; j++) begin : g_leaf
            assign node[NB+j] = SUM_W'(bytes_i[j*BYTE_W +: BYTE_W]);
         end
         for (genvar k = 1; k < NB; k++) begin : g_node
            assign node[k] = node[2*k] + node[2*k+1];
         end
         assign total = node[1];
      end else begin : g_chain
         always_comb begin
            total = '0;
            for (int j = 0; j < NB; j++) begin
               total = total + SUM_W'(bytes_i[j*BYTE_W +: BYTE_W]);
            end
         end
      end
   endgenerate

   assign sum_o = OUT_W'(total);

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
   import simd_sat_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int HALF_W   = 16,
   parameter int BYTE_W   = 8,
   parameter bit SUM_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   input  logic              ovf_clr,
   output logic [WORD_W-1:0] result,
   output logic              ovf_flag
);

   localparam int NH = WORD_W / HALF_W;
   localparam int NB = WORD_W / BYTE_W;

   generate
      if (WORD_W % HALF_W != 0) begin : g_bad_half
         $error("simd_sat_adder: WORD_W must be a multiple of HALF_W");
      end
      if (WORD_W % BYTE_W != 0) begin : g_bad_byte
         $error("simd_sat_adder: WORD_W must be a multiple of BYTE_W");
      end
      if (NB < 2) begin : g_bad_nb
         $error("simd_sat_adder: need at least two byte lanes");
      end
   endgenerate

   simd_ctl_t         ctl;
   logic [WORD_W-1:0] half_y;
   logic [WORD_W-1:0] byte_y;
   logic [WORD_W-1:0] habs_y;
   logic [WORD_W-1:0] wabs_y;
   logic [WORD_W-1:0] sum_y;
   logic [NH-1:0]     half_clip;
   logic [NH-1:0]     habs_clip;
   logic [NB-1:0]     byte_clip;
   logic              wabs_clip;
   logic [WORD_W-1:0] nxt_res;
   logic              nxt_clip;
   logic [WORD_W-1:0] result_q;
   logic              ovf_q;

   assign ctl = decode_op(op);

   generate
      for (genvar h = 0; h < NH; h++) begin : g_half
         simd_sat_lane #(
            .W           (HALF_W),
            .SIGNED_LANE (1'b1)
         ) u_lane (
            .a_i    (opnd_a[h*HALF_W +: HALF_W]),
            .b_i    (opnd_b[h*HALF_W +: HALF_W]),
            .sub_i  (ctl.sub),
            .sat_i  (ctl.sat),
            .y_o    (half_y[h*HALF_W +: HALF_W]),
            .clip_o (half_clip[h])
         );
         simd_abs_lane #(
            .W (HALF_W)
         ) u_abs (
            .a_i    (opnd_a[h*HALF_W +: HALF_W]),
            .y_o    (habs_y[h*HALF_W +: HALF_W]),
            .clip_o (habs_clip[h])
         );
      end
      for (genvar b = 0; b < NB; b++) begin : g_byte
         simd_sat_lane #(
            .W           (BYTE_W),
            .SIGNED_LANE (1'b0)
         ) u_lane (
            .a_i    (opnd_a[b*BYTE_W +: BYTE_W]),
            .b_i    (opnd_b[b*BYTE_W +: BYTE_W]),
            .sub_i  (ctl.sub),
            .sat_i  (ctl.sat),
            .y_o    (byte_y[b*BYTE_W +: BYTE_W]),
            .clip_o (byte_clip[b])
         );
      end
   endgenerate

   simd_abs_lane #(
      .W (WORD_W)
   ) u_word_abs (
      .a_i    (opnd_a),
      .y_o    (wabs_y),
      .clip_o (wabs_clip)
   );

   simd_byte_sum #(
      .NB       (NB),
      .BYTE_W   (BYTE_W),
      .OUT_W    (WORD_W),
      .USE_TREE (SUM_TREE)
   ) u_sum (
      .bytes_i (opnd_a),
      .sum_o   (sum_y)
   );

   always_comb begin
      nxt_res  = '0;
      nxt_clip = 1'b0;
      if (ctl.half_arith) begin
         nxt_res  = half_y;
         nxt_clip = |half_clip;
      end else if (ctl.byte_arith) begin
         nxt_res  = byte_y;
         nxt_clip = |byte_clip;
      end else if (ctl.half_abs) begin
         nxt_res  = habs_y;
         nxt_clip = |habs_clip;
      end else if (ctl.word_abs) begin
         nxt_res  = wabs_y;
         nxt_clip = wabs_clip;
      end else if (ctl.byte_sum) begin
         nxt_res  = sum_y;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (in_valid) begin
            result_q <= nxt_res;
         end
         // a clamp in the clearing cycle wins over the clear
         ovf_q <= (ovf_q & ~ovf_clr) | (in_valid & nxt_clip);
      end
   end

   assign result   = result_q;
   assign ovf_flag = ovf_q;

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
   import simd_sat_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int HALF_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   op,
   input logic [WORD_W-1:0] opnd_a,
   input logic [WORD_W-1:0] opnd_b,
   input logic              ovf_clr,
   input logic [WORD_W-1:0] result,
   input logic              ovf_flag
);

   localparam int NH    = WORD_W / HALF_W;
   localparam int NB    = WORD_W / BYTE_W;
   localparam int SUM_W = BYTE_W + $clog2(NB);

   logic wrap_op;
   assign wrap_op = (op == OP_HADD) || (op == OP_HSUB) ||
                    (op == OP_BADD) || (op == OP_BSUB);

   a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag);

   a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr && !in_valid |=> !ovf_flag);

   // R3 and R5: wrapping ops never raise the flag
   a_r3_r5_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && wrap_op && !ovf_flag && !ovf_clr |=> !ovf_flag);

   a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op > OP_BSUM) |=> result == '0);

   generate
      for (genvar j = 0; j < NB; j++) begin : g_byte_chk
         a_r6_add_not_below: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op == OP_BADD_SAT |=>
               result[j*BYTE_W +: BYTE_W] >= $past(opnd_a[j*BYTE_W +: BYTE_W]));
         a_r6_sub_not_above: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op == OP_BSUB_SAT |=>
               result[j*BYTE_W +: BYTE_W] <= $past(opnd_a[j*BYTE_W +: BYTE_W]));
      end
      for (genvar h = 0; h < NH; h++) begin : g_abs_chk
         a_r7_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op == OP_HABS_SAT |=> !result[h*HALF_W + HALF_W - 1]);
      end
      if (SUM_W < WORD_W) begin : g_sum_chk
         a_r9_sum_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op == OP_BSUM |=> result[WORD_W-1:SUM_W] == '0);
      end
   endgenerate

   a_r8_word_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_WABS_SAT |=> !result[WORD_W-1]);

endmodule

bind simd_sat_adder simd_sat_adder_chk #(
   .WORD_W (WORD_W),
   .HALF_W (HALF_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .ovf_clr  (ovf_clr),
   .result   (result),
   .ovf_flag (ovf_flag)
);

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
module simd_sat_adder_bench;

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] y;
      logic        f;
   } vec_t;

   localparam int NVEC = 20;

   localparam vec_t VECS [NVEC] = '{
      '{4'd0,  32'h5678_1234, 32'h1111_6F89, 32'h6789_81BD, 1'b0}, // R3
      '{4'd1,  32'h5678_1234, 32'h1111_6F89, 32'h6789_7FFF, 1'b1}, // R4
      '{4'd2,  32'h5678_1234, 32'h1111_6F89, 32'h4567_A2AB, 1'b0}, // R3
      '{4'd3,  32'h5678_8000, 32'h1111_6F89, 32'h4567_8000, 1'b1}, // R4
      '{4'd3,  32'h0001_FFFF, 32'h0002_0001, 32'hFFFF_FFFE, 1'b0}, // R4
      '{4'd1,  32'h8000_0001, 32'hFFFF_0001, 32'h8000_0002, 1'b1}, // R4
      '{4'd4,  32'h7856_34F2, 32'h1111_89FF, 32'h8967_BDF1, 1'b0}, // R5
      '{4'd5,  32'h7856_34F2, 32'h1111_89FF, 32'h8967_BDFF, 1'b1}, // R6
      '{4'd6,  32'h7856_34F2, 32'h1111_89FF, 32'h6745_ABF3, 1'b0}, // R5
      '{4'd7,  32'h7856_34F2, 32'h1111_89FF, 32'h6745_0000, 1'b1}, // R6
      '{4'd5,  32'h0102_0304, 32'h1010_1010, 32'h1112_1314, 1'b0}, // R6
      '{4'd8,  32'h8134_8000, 32'h0000_0000, 32'h7ECC_7FFF, 1'b1}, // R7
      '{4'd8,  32'h0005_FFFB, 32'h0000_0000, 32'h0005_0005, 1'b0}, // R7
      '{4'd9,  32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 1'b1}, // R8
      '{4'd9,  32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0002, 1'b0}, // R8
      '{4'd10, 32'h7856_34F2, 32'hFFFF_FFFF, 32'h0000_01F4, 1'b0}, // R9
      '{4'd10, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_03FC, 1'b0}, // R9
      '{4'd15, 32'h1234_5678, 32'h1111_1111, 32'h0000_0000, 1'b0}, // R11
      '{4'd0,  32'h7FFF_FFFF, 32'h0001_0001, 32'h8000_0000, 1'b0}, // R3
      '{4'd4,  32'hFFFF_FFFF, 32'h0101_0101, 32'h0000_0000, 1'b0}  // R5
   };

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic [3:0]  op;
   logic [31:0] opnd_a;
   logic [31:0] opnd_b;
   logic        ovf_clr;
   logic [31:0] result;
   logic        ovf_flag;

   int total;
   int bad;
   bit done;

   simd_sat_adder #(
      .WORD_W   (32),
      .HALF_W   (16),
      .BYTE_W   (8),
      .SUM_TREE (1'b1)
   ) u_simd_sat_adder (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op       (op),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .ovf_clr  (ovf_clr),
      .result   (result),
      .ovf_flag (ovf_flag)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   function automatic string req_of(input logic [3:0] code);
      case (code)
         4'd0, 4'd2: return "R3";
         4'd1, 4'd3: return "R4";
         4'd4, 4'd6: return "R5";
         4'd5, 4'd7: return "R6";
         4'd8:       return "R7";
         4'd9:       return "R8";
         4'd10:      return "R9";
         default:    return "R11";
      endcase
   endfunction

   task automatic check_word(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s result: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s ovf_flag: got %b expected %b", req, got, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the load
   task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic clr);
      op       = o;
      opnd_a   = a;
      opnd_b   = b;
      ovf_clr  = clr;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      ovf_clr  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      total    = 0;
      bad      = 0;
      done     = 1'b0;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      op       = 4'd0;
      opnd_a   = '0;
      opnd_b   = '0;
      ovf_clr  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_word("R1", result, 32'h0);
      check_bit("R1", ovf_flag, 1'b0);

      // table: each vector clears the flag, so the flag mirrors that op's clamping
      for (int i = 0; i < NVEC; i++) begin
         issue(VECS[i].op, VECS[i].a, VECS[i].b, 1'b1);
         check_word(req_of(VECS[i].op), result, VECS[i].y);
         check_bit(req_of(VECS[i].op), ovf_flag, VECS[i].f);
      end

      // R2: hold while in_valid is low
      issue(4'd0, 32'h0001_0001, 32'h0002_0002, 1'b1);
      check_word("R2", result, 32'h0003_0003);
      op     = 4'd9;
      opnd_a = 32'h8000_0000;
      opnd_b = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      check_word("R2", result, 32'h0003_0003);
      check_bit("R2", ovf_flag, 1'b0);

      // R10: sticky across a clean op, cleared by a lone clear
      issue(4'd1, 32'h0000_7FFF, 32'h0000_0001, 1'b0);
      check_bit("R10", ovf_flag, 1'b1);
      issue(4'd0, 32'h0000_0001, 32'h0000_0001, 1'b0);
      check_word("R10", result, 32'h0000_0002);
      check_bit("R10", ovf_flag, 1'b1);
      ovf_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ovf_clr = 1'b0;
      check_bit("R10", ovf_flag, 1'b0);
      // clamp and clear in the same cycle: flag set
      issue(4'd7, 32'h0000_0000, 32'h0000_0001, 1'b1);
      check_word("R10", result, 32'h0000_0000);
      check_bit("R10", ovf_flag, 1'b1);

      // R11: reserved code zeroes result and keeps the flag
      issue(4'd6, 32'h0000_0009, 32'h0000_0001, 1'b0);
      check_word("R5", result, 32'h0000_0008);
      issue(4'd12, 32'hDEAD_BEEF, 32'h0000_0001, 1'b0);
      check_word("R11", result, 32'h0000_0000);
      check_bit("R11", ovf_flag, 1'b1);

      // R1: asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      check_word("R1", result, 32'h0);
      check_bit("R1", ovf_flag, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule